// File: doc/BRIEF.md
# Fly-by DMA Channel Transfer Sequencer

This block is one channel of a fly-by DMA engine. It moves items between an I/O peripheral and memory without the data ever passing through it. The block watches the peripheral's request line. It asks for the system bus with a hold-request / hold-grant handshake. Once granted, it drives the low 16 address bits and one memory strobe plus one I/O strobe, and it acknowledges the peripheral. The peripheral and the memory then exchange the item directly on the data bus.

A host loads a start address, a count (the number of items minus one), a transfer mode, a direction and an autoinitialize flag with a one-cycle load pulse. The load also arms the channel. Single mode gives the bus back after every item. Block mode holds the bus until the count is exhausted. Demand mode holds the bus while the request stays high, and resumes later from where it stopped. At terminal count the channel either disarms itself or, with autoinitialize, reloads the programmed start values and stays armed.

All bus outputs come from a small state machine and the address/count registers, with no combinational path from any input. While the channel does not own the bus, its address and strobes sit at zero and `bus_oe_o` is low.

Top module: `dma_flyby_seq`

## Requirements
- R1: In reset and after reset, `hrq_o`, `dack_o`, `eop_o`, `bus_oe_o` and all four strobes are low, `addr_o` is 0 and `masked_o` is 1.
- R2: `hrq_o` rises one clock after a cycle in which `chan_en_i` is 1, `masked_o` is 0 and `drq_i` is 1. When any of these is missing, `hrq_o` stays low. After `hrq_o` rises, `bus_oe_o` stays low until `hlda_i` has been seen high, and it rises on the clock after that.
- R3: The direction flag `cfg_to_mem_i` is 1 for I/O-to-memory, which asserts `mem_wr_o` and `io_rd_o`. It is 0 for memory-to-I/O, which asserts `mem_rd_o` and `io_wr_o`. The other pair stays low.
- R4: Each transfer is one address setup clock with `bus_oe_o` high, followed by strobe clocks in which the strobes and `dack_o` are high. There is one strobe clock, plus one more for every clock in which `ready_i` is sampled low.
- R5: After each transfer the current address increments by one and wraps from 0xFFFF to 0x0000, and the current count decrements by one.
- R6: `eop_o` is high during the strobe clocks of the transfer whose current count is 0, so a loaded count N moves N+1 items.
- R7: In single mode (`cfg_mode_i` = 0) the bus is released after every item: one clock with only `hrq_o` high, then one clock with `hrq_o` low, before a new request is taken.
- R8: In block mode (`cfg_mode_i` = 1) the channel keeps the bus from the first item to terminal count whatever `drq_i` does after the first request.
- R9: In demand mode (`cfg_mode_i` = 2) a transfer is followed by another while `drq_i` is high at the end of its last strobe clock. Otherwise the bus is released and the channel stays armed, and a later request resumes at the saved address and count.
- R10: At terminal count without autoinitialize `masked_o` becomes 1. With autoinitialize the current address and count reload from the loaded values and `masked_o` stays 0. `cfg_load_i` clears `masked_o` and sets both the current and the base registers.
- R11: `hrq_o` falls only one clock after `dack_o` and all strobes have gone low.
- R12: While `bus_oe_o` is low, `addr_o` is 0 and `dack_o` and every strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load_i | input | 1 | Load pulse: writes base and current address/count, mode, direction, autoinit; arms the channel |
| cfg_addr_i | input | 16 | Start address |
| cfg_count_i | input | 16 | Item count minus one |
| cfg_mode_i | input | 2 | 0 single, 1 block, 2 demand (3 acts as single) |
| cfg_to_mem_i | input | 1 | 1 I/O-to-memory, 0 memory-to-I/O |
| cfg_autoinit_i | input | 1 | Reload at terminal count instead of disarming |
| chan_en_i | input | 1 | Channel enable |
| drq_i | input | 1 | Peripheral request |
| hlda_i | input | 1 | Bus grant from the host |
| ready_i | input | 1 | Low stretches the strobe phase |
| hrq_o | output | 1 | Bus request to the host |
| dack_o | output | 1 | Peripheral acknowledge |
| eop_o | output | 1 | Terminal count indication |
| bus_oe_o | output | 1 | Block is driving address and strobes |
| addr_o | output | 16 | Low address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| masked_o | output | 1 | Channel disarmed |

## Verification
Every pin is decoded directly from registered state, so a wrong sequencer state appears on `hrq_o`, `bus_oe_o` or `dack_o` in the very clock after the faulty edge. An address or count that stepped wrongly shows on `addr_o` at the next setup clock, or on `eop_o` at the wrong item. A mask bit that fails to set or clear shows on `masked_o` at once and on `hrq_o` at the next request. The bench runs a behavioural model of the pin sequence beside the design and compares all outputs each clock, across every mode, both directions, ready stretching, address wrap and autoinitialize.

// File: rtl/dma_seq_pkg.sv
// Shared types for the fly-by DMA channel sequencer.
// Assumes: mode codes are fixed by the host's programming convention.
package dma_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_BLOCK  = 2'd1,
        MODE_DEMAND = 2'd2,
        MODE_RSVD   = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HOLD    = 3'd1,
        ST_SETUP   = 3'd2,
        ST_XFER    = 3'd3,
        ST_RELEASE = 3'd4
    } seq_state_e;

endpackage

// File: rtl/dma_chan_regs.sv
// Channel registers: base and current address/count, mode, direction,
// autoinit flag and mask bit.
// Assumes: step_i pulses once per completed transfer; a load takes
// priority over a step in the same cycle.
module dma_chan_regs
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [AW-1:0] ld_addr_i,
    input  logic [CW-1:0] ld_cnt_i,
    input  xfer_mode_e    ld_mode_i,
    input  logic          ld_to_mem_i,
    input  logic          ld_auto_i,
    input  logic          step_i,
    output logic [AW-1:0] cur_addr_o,
    output logic          last_o,
    output logic          masked_o,
    output xfer_mode_e    mode_o,
    output logic          to_mem_o
);

    logic [AW-1:0] base_addr_q, cur_addr_q;
    logic [CW-1:0] base_cnt_q, cur_cnt_q;
    logic          auto_q, masked_q, to_mem_q;
    xfer_mode_e    mode_q;

    // Count is exhausted on the item whose current count is zero
    assign last_o     = (cur_cnt_q == '0);
    assign cur_addr_o = cur_addr_q;
    assign masked_o   = masked_q;
    assign mode_o     = mode_q;
    assign to_mem_o   = to_mem_q;

    // Programming, per-item stepping, reload and disarm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr_q <= '0;
            cur_addr_q  <= '0;
            base_cnt_q  <= '0;
            cur_cnt_q   <= '0;
            auto_q      <= 1'b0;
            to_mem_q    <= 1'b0;
            mode_q      <= MODE_SINGLE;
            masked_q    <= 1'b1;
        end else if (ld_i) begin
            base_addr_q <= ld_addr_i;
            cur_addr_q  <= ld_addr_i;
            base_cnt_q  <= ld_cnt_i;
            cur_cnt_q   <= ld_cnt_i;
            auto_q      <= ld_auto_i;
            to_mem_q    <= ld_to_mem_i;
            mode_q      <= ld_mode_i;
            masked_q    <= 1'b0;
        end else if (step_i) begin
            if (last_o && auto_q) begin
                cur_addr_q <= base_addr_q;
                cur_cnt_q  <= base_cnt_q;
            end else begin
                cur_addr_q <= cur_addr_q + 1'b1;
                cur_cnt_q  <= cur_cnt_q - 1'b1;
                if (last_o) masked_q <= 1'b1;
            end
        end
    end

    // R5: a mid-block step advances address (with wrap) and count
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !ld_i && !last_o) |=>
            (cur_addr_q == AW'($past(cur_addr_q) + 1'b1)) &&
            (cur_cnt_q == CW'($past(cur_cnt_q) - 1'b1)));

    // R10: autoinit reload restores the programmed values and keeps armed
    a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !ld_i && last_o && auto_q) |=>
            (cur_addr_q == base_addr_q) && (cur_cnt_q == base_cnt_q) && !masked_q);

    // R10: terminal count without autoinit disarms the channel
    a_r10_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !ld_i && last_o && !auto_q) |=> masked_q);

endmodule

// File: rtl/dma_seq_fsm.sv
// Transfer sequencer: request, grant wait, address setup, strobe phase
// and bus release, with the mode-dependent choice after each item.
// Assumes: go_i already combines enable, mask and request.
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic       drq_i,
    input  logic       hlda_i,
    input  logic       ready_i,
    input  logic       last_i,
    input  xfer_mode_e mode_i,
    output seq_state_e state_o,
    output logic       step_o
);

    seq_state_e state_q, state_d;

    assign state_o = state_q;
    // An item completes on a strobe clock that samples ready high
    assign step_o  = (state_q == ST_XFER) && ready_i;

    // Next-state choice
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (go_i) state_d = ST_HOLD;
            ST_HOLD:    if (hlda_i) state_d = ST_SETUP;
            ST_SETUP:   state_d = ST_XFER;
            ST_XFER: begin
                if (ready_i) begin
                    if (last_i) begin
                        state_d = ST_RELEASE;
                    end else begin
                        case (mode_i)
                            MODE_BLOCK:  state_d = ST_SETUP;
                            MODE_DEMAND: state_d = drq_i ? ST_SETUP : ST_RELEASE;
                            default:     state_d = ST_RELEASE;
                        endcase
                    end
                end
            end
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // R7: after every single-mode item the bus is handed back
    a_r7_single_release: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && mode_i == MODE_SINGLE) |=> (state_q == ST_RELEASE));

    // R2: no bus drive is reached without passing through the grant wait
    a_r2_setup_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP) |-> ($past(state_q) == ST_HOLD || $past(state_q) == ST_XFER));

endmodule

// File: rtl/dma_pin_drive.sv
// Decodes sequencer state, direction and current address onto the bus pins.
// Assumes: pins read zero whenever the block does not own the bus.
module dma_pin_drive
    import dma_seq_pkg::*;
#(
    parameter int AW = 16
) (
    input  seq_state_e    state_i,
    input  logic          to_mem_i,
    input  logic          last_i,
    input  logic [AW-1:0] cur_addr_i,
    output logic          hrq_o,
    output logic          oe_o,
    output logic [AW-1:0] addr_o,
    output logic          dack_o,
    output logic          eop_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic          io_rd_o,
    output logic          io_wr_o
);

    logic strobe;

    // Pin decode from state
    always_comb begin
        hrq_o    = (state_i != ST_IDLE);
        oe_o     = (state_i == ST_SETUP) || (state_i == ST_XFER);
        strobe   = (state_i == ST_XFER);
        addr_o   = oe_o ? cur_addr_i : '0;
        dack_o   = strobe;
        eop_o    = strobe && last_i;
        mem_wr_o = strobe && to_mem_i;
        io_rd_o  = strobe && to_mem_i;
        mem_rd_o = strobe && !to_mem_i;
        io_wr_o  = strobe && !to_mem_i;
    end

endmodule

// File: rtl/dma_flyby_seq.sv
// Single-channel fly-by DMA sequencer top: registers, sequencer and pin
// decode. Assumes the host loads the channel while it is idle.
module dma_flyby_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load_i,
    input  logic [AW-1:0] cfg_addr_i,
    input  logic [CW-1:0] cfg_count_i,
    input  logic [1:0]    cfg_mode_i,
    input  logic          cfg_to_mem_i,
    input  logic          cfg_autoinit_i,
    input  logic          chan_en_i,
    input  logic          drq_i,
    input  logic          hlda_i,
    input  logic          ready_i,
    output logic          hrq_o,
    output logic          dack_o,
    output logic          eop_o,
    output logic          bus_oe_o,
    output logic [AW-1:0] addr_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic          io_rd_o,
    output logic          io_wr_o,
    output logic          masked_o
);

    logic [AW-1:0] cur_addr;
    logic          last, masked, to_mem, step, go;
    xfer_mode_e    mode;
    seq_state_e    state;

    assign go       = chan_en_i && !masked && drq_i;
    assign masked_o = masked;

    dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_i       (cfg_load_i),
        .ld_addr_i  (cfg_addr_i),
        .ld_cnt_i   (cfg_count_i),
        .ld_mode_i  (xfer_mode_e'(cfg_mode_i)),
        .ld_to_mem_i(cfg_to_mem_i),
        .ld_auto_i  (cfg_autoinit_i),
        .step_i     (step),
        .cur_addr_o (cur_addr),
        .last_o     (last),
        .masked_o   (masked),
        .mode_o     (mode),
        .to_mem_o   (to_mem)
    );

    dma_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .drq_i   (drq_i),
        .hlda_i  (hlda_i),
        .ready_i (ready_i),
        .last_i  (last),
        .mode_i  (mode),
        .state_o (state),
        .step_o  (step)
    );

    dma_pin_drive #(.AW(AW)) u_pins (
        .state_i   (state),
        .to_mem_i  (to_mem),
        .last_i    (last),
        .cur_addr_i(cur_addr),
        .hrq_o     (hrq_o),
        .oe_o      (bus_oe_o),
        .addr_o    (addr_o),
        .dack_o    (dack_o),
        .eop_o     (eop_o),
        .mem_rd_o  (mem_rd_o),
        .mem_wr_o  (mem_wr_o),
        .io_rd_o   (io_rd_o),
        .io_wr_o   (io_wr_o)
    );

    // R11: bus request is withdrawn only after acknowledge and strobes ended
    a_r11_hrq_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hrq_o) |-> (!$past(dack_o) &&
            !$past(mem_rd_o || mem_wr_o || io_rd_o || io_wr_o)));

    // R2: bus drive starts only after the grant was seen
    a_r2_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe_o) |-> $past(hlda_i));

    // R3: exactly one matching strobe pair, never both
    a_r3_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o == io_rd_o) && (mem_rd_o == io_wr_o) && !(mem_wr_o && mem_rd_o));

    // R4: a strobe clock that samples ready low is followed by another
    a_r4_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (dack_o && !ready_i) |=> (dack_o && $stable(addr_o)));

    // R12: pins are quiet while the bus is not owned
    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_o |-> (addr_o == '0 && !dack_o && !mem_rd_o && !mem_wr_o && !io_rd_o && !io_wr_o));

    // R6: terminal count is only signalled during an acknowledged item
    a_r6_eop_dack: assert property (@(posedge clk) disable iff (!rst_n)
        eop_o |-> dack_o);

endmodule

// File: tb/dma_flyby_seq_bench.sv
// Bench: behavioural pin-level model compared with the design every clock,
// plus scenario checks per requirement.
module dma_flyby_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_load, cfg_to_mem, cfg_auto, chan_en, drq, hlda, ready;
    logic [15:0] cfg_addr, cfg_count;
    logic [1:0]  cfg_mode;
    logic        hrq, dack, eop, oe, mem_rd, mem_wr, io_rd, io_wr, masked;
    logic [15:0] addr;

    always #2 clk = ~clk;

    dma_flyby_seq u_dma_flyby_seq (
        .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load), .cfg_addr_i(cfg_addr),
        .cfg_count_i(cfg_count), .cfg_mode_i(cfg_mode), .cfg_to_mem_i(cfg_to_mem),
        .cfg_autoinit_i(cfg_auto), .chan_en_i(chan_en), .drq_i(drq), .hlda_i(hlda),
        .ready_i(ready), .hrq_o(hrq), .dack_o(dack), .eop_o(eop), .bus_oe_o(oe),
        .addr_o(addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .io_rd_o(io_rd),
        .io_wr_o(io_wr), .masked_o(masked)
    );

    int vectors = 0;
    int errors  = 0;
    int xfers   = 0;
    logic [15:0] addr_log[$];
    logic prev_dack = 1'b0;
    bit   grant_on  = 1'b1;

    // Model state: phase 0 idle, 1 requesting, 2 setup, 3 strobe, 4 release
    int          ph;
    logic [15:0] m_addr, m_cnt, b_addr, b_cnt;
    bit          m_mask, m_dir, m_auto;
    int          m_mode;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Host grant follows the request one clock later
    always @(negedge clk) hlda <= hrq && grant_on;

    // Model step at the edge, then full pin comparison
    always @(posedge clk) begin : model
        bit tc;
        if (!rst_n) begin
            ph = 0; m_addr = 0; m_cnt = 0; b_addr = 0; b_cnt = 0;
            m_mask = 1; m_dir = 0; m_auto = 0; m_mode = 0;
        end else begin
            case (ph)
                0: if (chan_en && !m_mask && drq) ph = 1;
                1: if (hlda) ph = 2;
                2: ph = 3;
                3: if (ready) begin
                       tc = (m_cnt == 0);
                       if (tc && m_auto) begin
                           m_addr = b_addr; m_cnt = b_cnt;
                       end else begin
                           m_addr = m_addr + 16'd1; m_cnt = m_cnt - 16'd1;
                           if (tc) m_mask = 1;
                       end
                       if (tc || m_mode == 0 || m_mode == 3) ph = 4;
                       else if (m_mode == 1) ph = 2;
                       else ph = drq ? 2 : 4;
                   end
                default: ph = 0;
            endcase
            if (cfg_load) begin
                b_addr = cfg_addr; m_addr = cfg_addr; b_cnt = cfg_count; m_cnt = cfg_count;
                m_mode = cfg_mode; m_dir = cfg_to_mem; m_auto = cfg_auto; m_mask = 0;
            end
        end
        #1;
        chk("R2 R11 hrq", hrq, (ph != 0));
        chk("R7 R12 bus_oe", oe, (ph == 2 || ph == 3));
        chk("R5 R12 addr", addr, (ph == 2 || ph == 3) ? m_addr : 0);
        chk("R4 dack", dack, ph == 3);
        chk("R3 mem_wr", mem_wr, ph == 3 && m_dir);
        chk("R3 io_rd", io_rd, ph == 3 && m_dir);
        chk("R3 mem_rd", mem_rd, ph == 3 && !m_dir);
        chk("R3 io_wr", io_wr, ph == 3 && !m_dir);
        chk("R6 eop", eop, ph == 3 && m_cnt == 0);
        chk("R10 masked", masked, m_mask);
        if (dack && !prev_dack) addr_log.push_back(addr);
        if (prev_dack && !dack) xfers++;
        prev_dack = dack;
    end

    task automatic load(input logic [15:0] a, input logic [15:0] n,
                        input logic [1:0] md, input logic dir, input logic au);
        cfg_addr = a; cfg_count = n; cfg_mode = md; cfg_to_mem = dir; cfg_auto = au;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stim
        int base;
        int lbase;
        rst_n = 0; cfg_load = 0; cfg_addr = 0; cfg_count = 0; cfg_mode = 0;
        cfg_to_mem = 0; cfg_auto = 0; chan_en = 0; drq = 0; ready = 1;
        repeat (3) @(negedge clk);
        chk("R1 reset hrq", hrq, 0);
        chk("R1 reset masked", masked, 1);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk("R1 after reset oe", oe, 0);

        // R2: disabled channel and masked channel ignore the request
        drq = 1; chan_en = 1;
        repeat (6) @(negedge clk);
        chk("R2 masked ignores drq", hrq, 0);
        load(16'h0040, 16'd0, 2'd0, 1'b1, 1'b0);
        chan_en = 0;
        repeat (6) @(negedge clk);
        chk("R2 disabled ignores drq", hrq, 0);

        // R2: grant withheld keeps the bus undriven
        grant_on = 0; chan_en = 1;
        repeat (6) @(negedge clk);
        chk("R2 waiting for grant hrq", hrq, 1);
        chk("R2 waiting for grant oe", oe, 0);
        grant_on = 1;
        repeat (10) @(negedge clk);
        drq = 0;
        repeat (4) @(negedge clk);

        // R6 R7: single mode, I/O to memory, count 2 moves three items
        base = xfers;
        load(16'h1000, 16'd2, 2'd0, 1'b1, 1'b0);
        drq = 1;
        repeat (40) @(negedge clk);
        drq = 0;
        repeat (4) @(negedge clk);
        chk("R6 single item count", xfers - base, 3);
        chk("R10 disarmed after tc", masked, 1);

        // R4: ready stretch, memory to I/O
        load(16'h2000, 16'd0, 2'd0, 1'b0, 1'b0);
        ready = 0; drq = 1;
        for (int i = 0; i < 20 && !dack; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R4 strobe held while not ready", dack, 1);
        ready = 1;
        @(negedge clk);
        chk("R4 strobe ends after ready", dack, 0);
        drq = 0;
        repeat (6) @(negedge clk);

        // R8: block mode runs to terminal count after a short request
        base = xfers;
        load(16'h3000, 16'd3, 2'd1, 1'b0, 1'b0);
        drq = 1;
        for (int i = 0; i < 20 && !dack; i++) @(negedge clk);
        drq = 0;
        repeat (30) @(negedge clk);
        chk("R8 block item count", xfers - base, 4);

        // R9: demand mode pauses when the request drops, then resumes
        base = xfers;
        load(16'h4000, 16'd5, 2'd2, 1'b1, 1'b0);
        drq = 1;
        for (int i = 0; i < 40 && (xfers - base) < 2; i++) @(negedge clk);
        drq = 0;
        repeat (8) @(negedge clk);
        chk("R9 paused bus released", hrq, 0);
        chk("R9 paused still armed", masked, 0);
        drq = 1;
        repeat (40) @(negedge clk);
        drq = 0;
        repeat (4) @(negedge clk);
        chk("R9 demand total items", xfers - base, 6);

        // R10: autoinitialize keeps the channel armed and reloads the address
        base = xfers; lbase = addr_log.size();
        load(16'h0020, 16'd1, 2'd0, 1'b1, 1'b1);
        drq = 1;
        repeat (40) @(negedge clk);
        chan_en = 0;
        repeat (8) @(negedge clk);
        drq = 0; chan_en = 1;
        chk("R10 autoinit still armed", masked, 0);
        chk("R10 autoinit keeps going", (xfers - base) >= 4, 1);
        chk("R10 reload address", addr_log[lbase + 2], 16'h0020);

        // R5: block across the address wrap
        lbase = addr_log.size();
        load(16'hFFFE, 16'd3, 2'd1, 1'b1, 1'b0);
        drq = 1;
        repeat (3) @(negedge clk);
        drq = 0;
        repeat (20) @(negedge clk);
        chk("R5 address before wrap", addr_log[lbase + 1], 16'hFFFF);
        chk("R5 address wraps to zero", addr_log[lbase + 2], 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule